// File: doc/BRIEF.md
# Grouped System-Management Interrupt Aggregator

The block collects a wide vector of device and pin interrupt events into one system-management interrupt request. Each source has its own sticky status bit and its own enable bit. Eight-bit enable registers hold the enables and are grouped into a bank. The grouped request is raised whenever at least one source has both its status and its enable set. The host reads and writes the block through a simple register port. Status bits are cleared by writing ones to them.

Two routing bits in the second enable register (index 1) are not source enables. They steer the grouped request to two places. Bit 7 sends it to an output pin. Bit 6 sends it to a request line that feeds serial-IRQ slot 2. The pin stage has two settings:
- a polarity setting, active low or active high;
- a drive setting, open-drain or push-pull.

The pin is modelled as a data value plus an output enable, so the pad and the serial framing stay outside the block.

Register map, with a 4-bit address:

| Address | Register | Access |
|---|---|---|
| 0 to 6 | Enable registers 0 to 6 | read/write |
| 8 to 14 | Status registers 0 to 6 | read; write 1 to clear |
| 15 | Pin configuration | read/write |
| 7 | Unmapped | reads as 0 |

Source `k` maps to bit `k mod 8` of register `k div 8`.

Top module: `smi_aggregator`

## Requirements
- R1: After reset, every enable and status bit is 0 and the configuration reads 0, which means active low with open-drain drive. In this state `pinOe`, `serIrqReq` and `smiGroup` are 0.
- R2: A 1 on `srcEvent[k]` at a clock edge sets status bit k. The bit then stays set, and reads back as 1 at status address 8+k/8, until the host clears it.
- R3: A host write to a status address clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: When a source event and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `smiGroup` is 1 exactly when some source bit has both status and enable set. The two routing bits of enable register 1 (bits 7 and 6) never count as sources.
- R6: The pin is asserted only while `smiGroup` is 1 and bit 7 of enable register 1 is 1.
- R7: `serIrqReq` equals `smiGroup` ANDed with bit 6 of enable register 1.
- R8: Configuration bit 1 sets the polarity. At 0 the asserted level is low; at 1 it is high.
- R9: Configuration bit 7 sets the drive.
  - At 1 (push-pull), `pinOe` is 1 and `pinData` is the pin level.
  - At 0 (open-drain), `pinData` is 0 and `pinOe` is 1 only while the pin level is low.
- R10: Enable registers read back all 8 written bits. The configuration register reads back only bits 7 and 1; its other bits and address 7 read 0.
- R11: Status bits 7 and 6 of register 1 have no source. They always read 0, even when the matching `srcEvent` bit pulses.

Every register change takes effect at the clock edge of the write or event. `smiGroup`, the pin outputs and `serIrqReq` follow from the registers with no further delay. `hostRdData` reflects the registers at the current address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcEvent | input | 56 | One-cycle event pulses, one per source |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 4 | Host register address |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Read data for `hostAddr` |
| smiGroup | output | 1 | Grouped request before routing |
| pinData | output | 1 | Pin data value |
| pinOe | output | 1 | Pin output enable |
| serIrqReq | output | 1 | Request for serial-IRQ slot 2 |

## Verification
Directed steps come first. They raise a single source with its enable both on and off, which separates the AND of status and enable from either input alone. They then clear with a zero mask and a one mask, and collide an event with a clear on the same bit. They also pulse a routing-bit source.

The four combinations of polarity and drive are each entered with the request both high and low. This tells the open-drain release apart from a driven inactive level.

Long random runs follow. They mix sparse events across all 56 sources with writes to any address. This shows whether a bit's position in the bank, its register and the routing exclusion are decoded correctly.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
  localparam int SMI_REGS = 7;
  localparam int SMI_REG_W = 8;
  localparam int SMI_SRC = SMI_REGS * SMI_REG_W;
  localparam int SMI_ADDR_W = 4;
  localparam int SMI_IDX_W = $clog2(SMI_REGS);
  localparam int ROUTE_REG = 1;
  localparam int PIN_ROUTE_BIT = 7;
  localparam int IRQ_ROUTE_BIT = 6;
  localparam int CFG_DRIVE_BIT = 7;
  localparam int CFG_POL_BIT = 1;
  localparam logic [SMI_ADDR_W-1:0] ADDR_CFG = 4'hF;

  typedef struct packed {
    logic [SMI_REGS-1:0]  enWr;
    logic [SMI_REGS-1:0]  stClr;
    logic                 cfgWr;
    logic [SMI_REG_W-1:0] data;
  } smi_strobe_t;

  typedef enum logic [1:0] {RD_NONE, RD_EN, RD_ST, RD_CFG} smi_rd_kind_t;

  // Mask of register bits that carry a real source.
  function automatic logic [SMI_REG_W-1:0] regSrcMask(input int r);
    logic [SMI_REG_W-1:0] m;
    m = '1;
    if (r == ROUTE_REG) begin
      m[PIN_ROUTE_BIT] = 1'b0;
      m[IRQ_ROUTE_BIT] = 1'b0;
    end
    return m;
  endfunction

  function automatic logic [SMI_SRC-1:0] srcMask();
    logic [SMI_SRC-1:0] m;
    for (int r = 0; r < SMI_REGS; r++) m[r*SMI_REG_W +: SMI_REG_W] = regSrcMask(r);
    return m;
  endfunction
endpackage

// File: rtl/smi_ctrl.sv
module smi_ctrl
  import smi_agg_pkg::*;
(
  input  logic                  hostWrEn,
  input  logic [SMI_ADDR_W-1:0] hostAddr,
  input  logic [SMI_REG_W-1:0]  hostWrData,
  output smi_strobe_t           strb,
  output smi_rd_kind_t          rdKind,
  output logic [SMI_IDX_W-1:0]  rdIdx
);
  logic                 bankSt;
  logic [SMI_IDX_W-1:0] idx;

  assign bankSt = hostAddr[SMI_ADDR_W-1];
  assign idx    = hostAddr[SMI_IDX_W-1:0];
  assign rdIdx  = idx;

  always_comb begin
    strb      = '0;
    strb.data = hostWrData;
    rdKind    = RD_NONE;
    if (hostAddr == ADDR_CFG) begin
      rdKind     = RD_CFG;
      strb.cfgWr = hostWrEn;
    end else if (int'(idx) < SMI_REGS) begin
      if (bankSt) begin
        rdKind          = RD_ST;
        strb.stClr[idx] = hostWrEn;
      end else begin
        rdKind         = RD_EN;
        strb.enWr[idx] = hostWrEn;
      end
    end
  end
endmodule

// File: rtl/smi_datapath.sv
module smi_datapath
  import smi_agg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  smi_strobe_t          strb,
  input  smi_rd_kind_t         rdKind,
  input  logic [SMI_IDX_W-1:0] rdIdx,
  input  logic [SMI_SRC-1:0]   srcEvent,
  output logic [SMI_SRC-1:0]   enVec,
  output logic [SMI_SRC-1:0]   stVec,
  output logic                 group,
  output logic                 pinRoute,
  output logic                 irqRoute,
  output logic                 cfgPushPull,
  output logic                 cfgActiveHigh,
  output logic [SMI_REG_W-1:0] rdData
);
  localparam logic [SMI_SRC-1:0] SRC_MASK = srcMask();

  logic [SMI_REGS-1:0][SMI_REG_W-1:0] enAll;
  logic [SMI_REGS-1:0][SMI_REG_W-1:0] stAll;

  for (genvar r = 0; r < SMI_REGS; r++) begin : g_reg
    localparam logic [SMI_REG_W-1:0] M = regSrcMask(r);
    logic [SMI_REG_W-1:0] enQ;
    logic [SMI_REG_W-1:0] stQ;
    logic [SMI_REG_W-1:0] clrMask;

    assign clrMask = strb.stClr[r] ? strb.data : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        enQ <= '0;
        stQ <= '0;
      end else begin
        if (strb.enWr[r]) enQ <= strb.data;
        stQ <= ((stQ & ~clrMask) | srcEvent[r*SMI_REG_W +: SMI_REG_W]) & M;
      end
    end

    assign enAll[r] = enQ;
    assign stAll[r] = stQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgPushPull   <= 1'b0;
      cfgActiveHigh <= 1'b0;
    end else if (strb.cfgWr) begin
      cfgPushPull   <= strb.data[CFG_DRIVE_BIT];
      cfgActiveHigh <= strb.data[CFG_POL_BIT];
    end
  end

  assign enVec    = enAll;
  assign stVec    = stAll;
  assign group    = |(stVec & enVec & SRC_MASK);
  assign pinRoute = enAll[ROUTE_REG][PIN_ROUTE_BIT];
  assign irqRoute = enAll[ROUTE_REG][IRQ_ROUTE_BIT];

  always_comb begin
    rdData = '0;
    case (rdKind)
      RD_EN:  rdData = enAll[rdIdx];
      RD_ST:  rdData = stAll[rdIdx];
      RD_CFG: begin
        rdData[CFG_DRIVE_BIT] = cfgPushPull;
        rdData[CFG_POL_BIT]   = cfgActiveHigh;
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/smi_pin_stage.sv
module smi_pin_stage (
  input  logic group,
  input  logic pinRoute,
  input  logic irqRoute,
  input  logic activeHigh,
  input  logic pushPull,
  output logic pinData,
  output logic pinOe,
  output logic serIrqReq
);
  logic asserted;
  logic level;

  assign asserted  = group & pinRoute;
  assign level     = activeHigh ? asserted : ~asserted;
  assign serIrqReq = group & irqRoute;

  always_comb begin
    if (pushPull) begin
      pinData = level;
      pinOe   = 1'b1;
    end else begin
      pinData = 1'b0;
      pinOe   = ~level;
    end
  end
endmodule

// File: rtl/smi_aggregator.sv
module smi_aggregator
  import smi_agg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SMI_SRC-1:0]    srcEvent,
  input  logic                  hostWrEn,
  input  logic [SMI_ADDR_W-1:0] hostAddr,
  input  logic [SMI_REG_W-1:0]  hostWrData,
  output logic [SMI_REG_W-1:0]  hostRdData,
  output logic                  smiGroup,
  output logic                  pinData,
  output logic                  pinOe,
  output logic                  serIrqReq
);
  smi_strobe_t          strb;
  smi_rd_kind_t         rdKind;
  logic [SMI_IDX_W-1:0] rdIdx;
  logic [SMI_SRC-1:0]   enVec;
  logic [SMI_SRC-1:0]   stVec;
  logic                 pinRoute;
  logic                 irqRoute;
  logic                 cfgPushPull;
  logic                 cfgActiveHigh;

  smi_ctrl u_ctrl (
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .strb      (strb),
    .rdKind    (rdKind),
    .rdIdx     (rdIdx)
  );

  smi_datapath u_dp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .rdKind       (rdKind),
    .rdIdx        (rdIdx),
    .srcEvent     (srcEvent),
    .enVec        (enVec),
    .stVec        (stVec),
    .group        (smiGroup),
    .pinRoute     (pinRoute),
    .irqRoute     (irqRoute),
    .cfgPushPull  (cfgPushPull),
    .cfgActiveHigh(cfgActiveHigh),
    .rdData       (hostRdData)
  );

  smi_pin_stage u_pin (
    .group     (smiGroup),
    .pinRoute  (pinRoute),
    .irqRoute  (irqRoute),
    .activeHigh(cfgActiveHigh),
    .pushPull  (cfgPushPull),
    .pinData   (pinData),
    .pinOe     (pinOe),
    .serIrqReq (serIrqReq)
  );
endmodule

// File: rtl/smi_aggregator_chk.sv
module smi_aggregator_chk
  import smi_agg_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [SMI_SRC-1:0]    srcEvent,
  input logic                  hostWrEn,
  input logic [SMI_ADDR_W-1:0] hostAddr,
  input logic [SMI_REG_W-1:0]  hostWrData,
  input logic [SMI_SRC-1:0]    stVec,
  input logic                  smiGroup,
  input logic                  pinData,
  input logic                  pinOe,
  input logic                  serIrqReq,
  input logic                  cfgPushPull,
  input logic                  cfgActiveHigh
);
  localparam logic [SMI_SRC-1:0] SRC_MASK = srcMask();

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!pinOe && !serIrqReq && !smiGroup));

  // R2 and R4: an event always leaves its status bit set.
  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|(srcEvent & SRC_MASK)) |=>
      ((stVec & $past(srcEvent & SRC_MASK)) == $past(srcEvent & SRC_MASK)));

  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (hostWrEn && hostAddr[SMI_ADDR_W-1] && hostAddr != ADDR_CFG
     && int'(hostAddr[SMI_IDX_W-1:0]) < SMI_REGS && srcEvent == '0) |=>
      ((stVec[$past(hostAddr[SMI_IDX_W-1:0])*SMI_REG_W +: SMI_REG_W]
        & $past(hostWrData)) == '0));

  a_r7_irq_needs_group: assert property (@(posedge clk) disable iff (rst)
    serIrqReq |-> smiGroup);

  a_r6_idle_released: assert property (@(posedge clk) disable iff (rst)
    (!smiGroup && !cfgPushPull && !cfgActiveHigh) |-> !pinOe);

  a_r9_od_data_low: assert property (@(posedge clk) disable iff (rst)
    !cfgPushPull |-> !pinData);

  a_r9_pp_driven: assert property (@(posedge clk) disable iff (rst)
    cfgPushPull |-> pinOe);
endmodule

bind smi_aggregator smi_aggregator_chk u_chk (.*);

// File: tb/smi_aggregator_tb.sv
module smi_aggregator_tb;
  import smi_agg_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SMI_SRC-1:0]    srcEvent = '0;
  logic                  hostWrEn = 1'b0;
  logic [SMI_ADDR_W-1:0] hostAddr = '0;
  logic [SMI_REG_W-1:0]  hostWrData = '0;
  logic [SMI_REG_W-1:0]  hostRdData;
  logic smiGroup, pinData, pinOe, serIrqReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] mEn [SMI_REGS];
  logic [7:0] mSt [SMI_REGS];
  logic mDrv, mPol;

  always #2 clk = ~clk;

  smi_aggregator u_dut (
    .clk(clk), .rst(rst), .srcEvent(srcEvent), .hostWrEn(hostWrEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .smiGroup(smiGroup), .pinData(pinData), .pinOe(pinOe), .serIrqReq(serIrqReq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRd(input logic [3:0] a);
    if (a == 4'hF) return {mDrv, 5'b0, mPol, 1'b0};
    if (a[2:0] == 3'd7) return 8'h00;
    return a[3] ? mSt[a[2:0]] : mEn[a[2:0]];
  endfunction

  function automatic logic expGroup();
    logic g = 1'b0;
    for (int r = 0; r < SMI_REGS; r++) begin
      logic [7:0] m = (r == 1) ? 8'h3F : 8'hFF;
      if ((mSt[r] & mEn[r] & m) != 0) g = 1'b1;
    end
    return g;
  endfunction

  // Returns {pinData, pinOe}.
  function automatic logic [1:0] expPin();
    logic as = expGroup() & mEn[1][7];
    logic lv = mPol ? as : ~as;
    return mDrv ? {lv, 1'b1} : {1'b0, ~lv};
  endfunction

  function automatic string rdTag(input logic [3:0] a);
    if (a == 4'hF || a[2:0] == 3'd7) return "R10 cfg/unmapped read";
    if (a[3]) return (a[2:0] == 3'd1) ? "R2 R11 status read" : "R2 status read";
    return "R10 enable read";
  endfunction

  task automatic step(input logic [SMI_SRC-1:0] ev, input logic wr,
                      input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    srcEvent = ev; hostWrEn = wr; hostAddr = a; hostWrData = d;
    #1;
    chk(rdTag(a), hostRdData, expRd(a));
    for (int r = 0; r < SMI_REGS; r++) begin
      logic [7:0] clr = (wr && a[3] && a != 4'hF && a[2:0] == 3'(r)) ? d : 8'h00;
      logic [7:0] m = (r == 1) ? 8'h3F : 8'hFF;
      mSt[r] = ((mSt[r] & ~clr) | ev[r*8 +: 8]) & m;
    end
    if (wr && !a[3] && a[2:0] != 3'd7) mEn[a[2:0]] = d;
    if (wr && a == 4'hF) begin mDrv = d[7]; mPol = d[1]; end
    @(posedge clk);
    #1;
    chk("R5 group", {7'b0, smiGroup}, {7'b0, expGroup()});
    chk("R7 serirq", {7'b0, serIrqReq}, {7'b0, expGroup() & mEn[1][6]});
    chk("R6 R8 R9 pin", {6'b0, pinData, pinOe}, {6'b0, expPin()});
  endtask

  function automatic logic [SMI_SRC-1:0] bitOf(input int k);
    logic [SMI_SRC-1:0] v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < SMI_REGS; r++) begin mEn[r] = 0; mSt[r] = 0; end
    mDrv = 0; mPol = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 pinOe", {7'b0, pinOe}, 8'h00);
    chk("R1 serirq", {7'b0, serIrqReq}, 8'h00);
    chk("R1 group", {7'b0, smiGroup}, 8'h00);
    hostAddr = 4'hF; #1 chk("R1 cfg", hostRdData, 8'h00);
    hostAddr = 4'h1; #1 chk("R1 en1", hostRdData, 8'h00);

    step(bitOf(3), 1'b0, 4'h8, 8'h00);             // status set, no enable
    chk("R5 no enable", {7'b0, smiGroup}, 8'h00);
    step('0, 1'b1, 4'h0, 8'h08);                    // enable it
    chk("R5 enabled", {7'b0, smiGroup}, 8'h01);
    chk("R6 pin not routed", {7'b0, pinOe}, 8'h00);
    step('0, 1'b1, 4'h1, 8'h80);                    // route to pin
    chk("R9 od low driven", {6'b0, pinData, pinOe}, 8'h01);
    step('0, 1'b1, 4'h8, 8'h00);                    // clear with zero mask
    chk("R3 zero mask keeps", {7'b0, smiGroup}, 8'h01);
    step('0, 1'b1, 4'h8, 8'h08);
    chk("R3 cleared", {7'b0, smiGroup}, 8'h00);
    step(bitOf(3), 1'b1, 4'h8, 8'hFF);              // collision
    chk("R4 set wins", {7'b0, smiGroup}, 8'h01);
    step('0, 1'b1, 4'h1, 8'hC0);
    chk("R7 irq routed", {7'b0, serIrqReq}, 8'h01);
    step('0, 1'b1, 4'hF, 8'h82);                    // push-pull active high
    chk("R8 R9 pp high", {6'b0, pinData, pinOe}, 8'h03);
    step('0, 1'b1, 4'h8, 8'h08);
    chk("R8 R9 pp idle low", {6'b0, pinData, pinOe}, 8'h01);
    step('0, 1'b1, 4'hF, 8'h02);                    // open-drain active high
    chk("R9 od active-high idle", {6'b0, pinData, pinOe}, 8'h01);
    step(bitOf(15) | bitOf(14), 1'b1, 4'h1, 8'hFF);  // routing-bit sources
    step('0, 1'b0, 4'h9, 8'h00);
    hostAddr = 4'h9; #1 chk("R11 route status", hostRdData, 8'h00);
    chk("R11 no group", {7'b0, smiGroup}, 8'h00);
    step('0, 1'b1, 4'hF, 8'h7D);
    hostAddr = 4'hF; #1 chk("R10 cfg reserved", hostRdData, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      logic [SMI_SRC-1:0] ev = '0;
      logic [3:0] a = 4'($urandom_range(0, 15));
      for (int k = 0; k < SMI_SRC; k++) ev[k] = ($urandom_range(0, 23) == 0);
      step(ev, ($urandom_range(0, 2) != 0), a, 8'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule